// File: doc/BRIEF.md
# Converter serial readout port

This block models, in synthesizable form, the device side of an analog-to-digital converter's serial result port. A conversion-start pin, a serial clock pin and a serial data input come from the host. The converter answers on a serial data output that has a separate drive enable, so the surrounding logic can build a tri-state pin. All three pin inputs are brought into the system clock domain through two-flop synchronizers, and their edges are detected there. The analog conversion itself is not modelled. A timer of `CONV_CYCLES` system clocks stands in for it, and when the timer expires the block captures the 16-bit parallel `result` input.

A rising edge on the start pin latches the operating mode from the serial input. A high level selects a select-gated mode, in which the start pin acts as an active-low chip select for the readout. A low level selects a cascade mode, in which several devices form one long shift register through their serial inputs. The same edge also fixes whether a leading busy bit is sent. In cascade mode the serial clock level at the edge decides this. In select-gated mode the start and serial-input levels at the end of the conversion decide it. Data leave MSB first, and each bit after the first is advanced by a falling edge of the serial clock.

Top module: `adc_serial_port`

## Requirements
- R1: While reset is asserted, and directly after it, `dout_en` and `dout` are both 0.
- R2: At a start rising edge, `din` high selects select-gated mode and `din` low selects cascade mode. In cascade mode the output is enabled after conversion end even while `start` is still high. In select-gated mode it is not.
- R3: A start rising edge outside a conversion releases the output (`dout_en`=0). The only exception is cascade mode with busy enabled.
- R4: A conversion lasts `CONV_CYCLES` system clocks after the synchronized start edge. Further start rising edges during a conversion are ignored and do not restart the timer.
- R5: In select-gated mode without busy, the result MSB appears on `dout` once `start` is low after conversion end. Each later `sclk` falling edge advances one bit, from bit 15 down to bit 0.
- R6: In select-gated mode the output is released after the last result bit has been followed by one more `sclk` falling edge, or earlier if `start` rises. While `start` is high the output stays released.
- R7: In select-gated mode, if `start` or `din` is low when the conversion ends, a start bit of value 1 precedes the MSB. While `start` is low during a conversion, `dout` is driven 0.
- R8: In cascade mode, `sclk` high at the start rising edge enables busy. `dout` is then driven 0 for the whole conversion, becomes 1 at conversion end, and the first `sclk` falling edge after that brings out the MSB.
- R9: In cascade mode each `sclk` falling edge that advances the data shifts `din` in behind the result. After the 16 result bits, `dout` carries the `din` values in the order they were shifted in, and the output stays enabled until the next start rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion start, also the chip select in select-gated mode |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data input: mode strap and cascade input |
| result | input | DATA_W | Parallel conversion result, captured at conversion end |
| dout | output | 1 | Serial data output |
| dout_en | output | 1 | Drive enable for the serial data output |

## Verification
The assertions assume two things about the pins. First, each pin holds a level for at least two system clocks, so the synchronizers never drop a pulse. Second, `result` is stable at the moment the conversion timer expires. The bench meets both conditions by changing one pin at a time on the falling system clock and then waiting four cycles. It also sets `din` and `sclk` several cycles before each start edge, so that the mode and busy choice are sampled from settled levels, and it holds `result` constant for each whole transaction.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sclk,
  input  logic              din,
  input  logic [DATA_W-1:0] result,
  output logic              dout,
  output logic              dout_en
);
  localparam int TM_W  = $clog2(CONV_CYCLES + 1);
  localparam int CNT_W = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_READ} state_t;

  logic [1:0] sync_start, sync_sclk, sync_din;
  logic       start_q, sclk_q;
  state_t     state;
  logic       chain, busy_pend;
  logic [DATA_W-1:0] sreg;
  logic [CNT_W-1:0]  bits_left;
  logic [TM_W-1:0]   timer;

  wire start_s    = sync_start[1];
  wire sclk_s     = sync_sclk[1];
  wire din_s      = sync_din[1];
  wire start_rise = start_s & ~start_q;
  wire sclk_fall  = ~sclk_s & sclk_q;
  wire selected   = chain | ~start_s;
  wire advance    = (state == ST_READ) & sclk_fall & selected;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_start <= '0;
      sync_sclk  <= '0;
      sync_din   <= '0;
      start_q    <= 1'b0;
      sclk_q     <= 1'b0;
    end else begin
      sync_start <= {sync_start[0], start};
      sync_sclk  <= {sync_sclk[0], sclk};
      sync_din   <= {sync_din[0], din};
      start_q    <= start_s;
      sclk_q     <= sclk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      chain     <= 1'b0;
      busy_pend <= 1'b0;
      sreg      <= '0;
      bits_left <= '0;
      timer     <= '0;
    end else if (start_rise && state != ST_CONV) begin
      state     <= ST_CONV;
      chain     <= ~din_s;
      busy_pend <= ~din_s & sclk_s;
      timer     <= TM_W'(CONV_CYCLES);
    end else begin
      case (state)
        ST_CONV: begin
          timer <= timer - 1'b1;
          if (timer <= TM_W'(1)) begin
            state     <= ST_READ;
            sreg      <= result;
            bits_left <= CNT_W'(DATA_W);
            if (!chain) busy_pend <= ~start_s | ~din_s;
          end
        end
        ST_READ: begin
          if (advance) begin
            if (busy_pend) begin
              busy_pend <= 1'b0;
            end else begin
              sreg <= {sreg[DATA_W-2:0], din_s};
              if (!chain) begin
                bits_left <= bits_left - 1'b1;
                if (bits_left == CNT_W'(1)) state <= ST_IDLE;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign dout_en = (state == ST_CONV) ? (chain ? busy_pend : ~start_s)
                 : (state == ST_READ) ? selected : 1'b0;
  assign dout    = dout_en & (state == ST_READ) & (busy_pend | sreg[DATA_W-1]);

  a_r3_release_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise && state != ST_CONV && !(!din_s && sclk_s) |=> !dout_en);

  a_r4_conv_runs: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_CONV && timer > TM_W'(1) |=> state == ST_CONV);

  a_r8_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_CONV && chain && busy_pend |-> dout_en && !dout);

  a_r5_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_READ && !sclk_fall && !start_rise |=> $stable(sreg));

  a_r9_chain_stays_on: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_READ && chain && !start_rise |=> dout_en);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bits_left <= CNT_W'(DATA_W));
endmodule

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, sclk = 1'b0, din = 1'b1;
  logic [15:0] result = '0;
  logic dout, dout_en;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  adc_serial_port #(.DATA_W(16), .CONV_CYCLES(20)) i_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .start(start), .sclk(sclk), .din(din),
    .result(result), .dout(dout), .dout_en(dout_en));

  // bit 16: busy requested by holding start low through the conversion
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 16'hA5C3}, {1'b0, 16'h0001}, {1'b0, 16'h8000},
    {1'b1, 16'h5A3C}, {1'b1, 16'hFFFF}, {1'b0, 16'h0000}};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {en,dout} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input logic d);
    sclk = 1'b1; din = d; tick(4);
    sclk = 1'b0; tick(4);
  endtask

  task automatic cs_read(input logic [15:0] val, input logic busy);
    start = 1'b0; din = 1'b1; sclk = 1'b0; tick(4);
    result = val;
    start = 1'b1; tick(4);
    if (busy) begin
      start = 1'b0; tick(6);
      check("R7 driven low during conversion", {dout_en, dout}, 2'b10);
      tick(24);
      check("R7 start bit", {dout_en, dout}, 2'b11);
      pulse(1'b1);
    end else begin
      tick(26);
      check("R6 released while start high", {dout_en, dout}, 2'b00);
      start = 1'b0; tick(4);
    end
    check("R5 MSB", {dout_en, dout}, {1'b1, val[15]});
    for (int i = 14; i >= 0; i--) begin
      pulse(1'b1);
      check("R5 data bit", {dout_en, dout}, {1'b1, val[i]});
    end
    pulse(1'b1);
    check("R6 release after last bit", {dout_en, dout}, 2'b00);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [19:0] pat;
    logic [15:0] cv;
    tick(3);
    check("R1 in reset", {dout_en, dout}, 2'b00);
    rst_n = 1'b1; tick(4);
    check("R1 after reset", {dout_en, dout}, 2'b00);

    foreach (VEC[k]) cs_read(VEC[k][15:0], VEC[k][16]);

    // R4: a second start edge during conversion must not restart the timer
    start = 1'b0; din = 1'b1; sclk = 1'b0; result = 16'h1234; tick(4);
    start = 1'b1; tick(6); start = 1'b0; tick(4); start = 1'b1; tick(4); start = 1'b0; tick(4);
    check("R4 still converting", {dout_en, dout}, 2'b10);
    tick(8);
    check("R4 ends on time", {dout_en, dout}, 2'b11);
    pulse(1'b1);
    check("R7 MSB after start bit", {dout_en, dout}, 2'b10);

    // R6: early release when start rises mid-read
    start = 1'b1; tick(4);
    check("R6 early release", {dout_en, dout}, 2'b00);
    tick(30);

    // R2/R3: cascade mode without busy
    start = 1'b0; din = 1'b0; sclk = 1'b0; result = 16'hC00F; tick(4);
    start = 1'b1; tick(10);
    check("R3 released during conversion", {dout_en, dout}, 2'b00);
    tick(20);
    check("R2 cascade drives with start high", {dout_en, dout}, 2'b11);
    pulse(1'b0);
    check("R9 second bit", {dout_en, dout}, 2'b11);

    // R8/R9: cascade with busy, then data passes through
    start = 1'b0; din = 1'b0; sclk = 1'b1; cv = 16'h9E61; result = cv; tick(4);
    start = 1'b1; tick(10);
    check("R8 busy low", {dout_en, dout}, 2'b10);
    tick(20);
    check("R8 start bit high", {dout_en, dout}, 2'b11);
    sclk = 1'b0; tick(4);
    check("R8 MSB after start bit", {dout_en, dout}, {1'b1, cv[15]});
    pat = 20'hB3A5D;
    for (int i = 0; i < 20; i++) begin
      pulse(pat[i]);
      if (i < 15) check("R9 result bit", {dout_en, dout}, {1'b1, cv[14-i]});
      else check("R9 upstream bit", {dout_en, dout}, {1'b1, pat[i-15]});
    end
    start = 1'b0; tick(2);
    start = 1'b1; tick(4);
    check("R3 cascade release on start", {dout_en, dout}, 2'b00);
    tick(30);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule